// File: doc/BRIEF.md
# Configurable Watchdog Supervisor

This block watches over software running elsewhere on the chip. Software controls it through one 8-bit register. The low three bits hold a timing code. Bit 3 is the service (kick) line, which software pulses by writing the byte once with the bit set and once with it clear. The code picks two times. The first is a start-up grace time, during which the block does not supervise. The second is the service period that software must then keep to. One code switches supervision off. A one-second enable pulse from outside sets the time base, so every time is a whole number of such ticks. When a period ends without a service, the block raises a one-clock `expired` pulse. A reset controller or an interrupt line can use that pulse.

A parameter picks one of two code tables. The basic table has only codes with a grace time. The extended table adds codes with no grace time. With one of those codes, the block waits for the first service edge before supervision starts. When a code has no entry in the selected table, the block treats it as off. A read returns the last byte written. Software can therefore change one field and write the other bits back unchanged.

Top module: `wdg_supervisor`

## Requirements
- R1: A synchronous active-high `rst` sets the register to 8'h03 (supervision off) and clears all timing state. After reset, `expired` stays low.
- R2: `rd_data` always shows the last byte accepted with `wr_en`, all eight bits.
- R3: Bits 2:0 of the register hold the timing code and bit 3 is the service line. A service event is a write that takes bit 3 from 0 to 1. A write that keeps bits 2:0 unchanged does not restart timing.
- R4: Basic table (EXTENDED=0): code 5 gives a 1-tick grace and a 1-tick period, code 6 gives 10 and 10, and code 7 gives 60 and 60. With no service, the first `expired` pulse therefore follows tick 2, 20 or 120 after the code is written.
- R5: Extended table (EXTENDED=1), codes with a grace time: code 1 gives 3 and 3, code 2 gives 60 and 1, and code 7 gives 60 and 10. The first `expired` pulse follows tick 6, 61 or 70.
- R6: Extended table, codes 5 and 6: no grace time and periods of 1 and 10 ticks. The period does not start, and no ticks count, until the first service event after the code is written.
- R7: Code 3, and every code that has no entry in the selected table, never produces `expired`, whatever ticks or service events arrive.
- R8: A service event during the grace time has no effect. The period starts only when the grace time runs out.
- R9: A service event while supervising reloads the full period. If a tick arrives in the same clock, the service event wins.
- R10: `expired` is high for exactly one clock. It follows the clock edge that sampled the tick emptying the period. The period then reloads and supervision goes on, so ticks that keep coming with no service give one pulse per period.
- R11: Timing state changes only on clocks where `sec_tick` is high. Idle clocks between ticks neither move the count nor cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-clock pulse per second of time base |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write: code in 2:0, service line in 3 |
| rd_data | output | 8 | Last byte written |
| expired | output | 1 | One-clock pulse when a service period runs out |

## Verification
A wrong count or a count that never reloads shows at the port as an `expired` pulse one tick early or late. It can also show as a missing second pulse in a run of ticks. The bench therefore counts ticks up to the first pulse and counts the pulses over a long run. A state error appears at the port too, whether the block stays armed when it should be watching or watches during the grace time. Such an error moves or removes the first pulse by whole grace or period lengths, so for the 60-tick codes it is seen only after up to 120 ticks. A register or decode error shows at once on `rd_data`, or as a pulse from a code that must stay silent.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int TIME_W   = 6;
    localparam int CODE_W   = 3;
    localparam int KICK_BIT = 3;
    localparam logic [7:0] RESET_BYTE = 8'h03;

    typedef logic [TIME_W-1:0] wd_time_t;
    typedef logic [CODE_W-1:0] wd_code_t;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_GRACE = 2'd1,
        WD_ARMED = 2'd2,
        WD_WATCH = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic     enabled;
        wd_time_t grace;
        wd_time_t period;
    } wd_timing_t;

    function automatic wd_timing_t mk_timing(input logic en, input int g, input int p);
        wd_timing_t t;
        t.enabled = en;
        t.grace   = wd_time_t'(g);
        t.period  = wd_time_t'(p);
        return t;
    endfunction

    function automatic wd_timing_t basic_lookup(input wd_code_t code);
        case (code)
            3'd5:    return mk_timing(1'b1, 1, 1);
            3'd6:    return mk_timing(1'b1, 10, 10);
            3'd7:    return mk_timing(1'b1, 60, 60);
            default: return mk_timing(1'b0, 0, 0);
        endcase
    endfunction

    function automatic wd_timing_t ext_lookup(input wd_code_t code);
        case (code)
            3'd1:    return mk_timing(1'b1, 3, 3);
            3'd2:    return mk_timing(1'b1, 60, 1);
            3'd5:    return mk_timing(1'b1, 0, 1);
            3'd6:    return mk_timing(1'b1, 0, 10);
            3'd7:    return mk_timing(1'b1, 60, 10);
            default: return mk_timing(1'b0, 0, 0);
        endcase
    endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       cfg_change,
    output logic       kick
);
    logic [7:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= RESET_BYTE;
        end else if (wr_en) begin
            byte_q <= wr_data;
        end
    end

    assign rd_data    = byte_q;
    assign cfg_change = wr_en && (wr_data[CODE_W-1:0] != byte_q[CODE_W-1:0]);
    assign kick       = wr_en && wr_data[KICK_BIT] && !byte_q[KICK_BIT];

    p_readback_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> (rd_data == $past(wr_data)));

    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == RESET_BYTE));

endmodule

// File: rtl/wdg_code_map.sv
module wdg_code_map
    import wdg_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  wd_code_t   code,
    output wd_timing_t timing
);
    generate
        if (EXTENDED) begin : g_ext
            assign timing = ext_lookup(code);
        end else begin : g_basic
            assign timing = basic_lookup(code);
        end
    endgenerate

    always_comb begin
        if (timing.enabled) begin
            a_period_nonzero_r7: assert (timing.period != '0);
        end
    end

endmodule

// File: rtl/wdg_timer_core.sv
module wdg_timer_core
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cfg_change,
    input  logic       kick,
    input  wd_timing_t new_timing,
    output logic       expired
);
    wd_state_e state_q;
    wd_time_t  cnt_q;
    wd_time_t  per_q;
    logic      exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
            per_q   <= '0;
            exp_q   <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (cfg_change) begin
                per_q <= new_timing.period;
                if (!new_timing.enabled) begin
                    state_q <= WD_OFF;
                    cnt_q   <= '0;
                end else if (new_timing.grace == '0) begin
                    state_q <= WD_ARMED;
                    cnt_q   <= '0;
                end else begin
                    state_q <= WD_GRACE;
                    cnt_q   <= new_timing.grace;
                end
            end else begin
                case (state_q)
                    WD_GRACE: begin
                        if (tick) begin
                            if (cnt_q == wd_time_t'(1)) begin
                                state_q <= WD_WATCH;
                                cnt_q   <= per_q;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    WD_ARMED: begin
                        if (kick) begin
                            state_q <= WD_WATCH;
                            cnt_q   <= per_q;
                        end
                    end
                    WD_WATCH: begin
                        if (kick) begin
                            cnt_q <= per_q;
                        end else if (tick) begin
                            if (cnt_q == wd_time_t'(1)) begin
                                exp_q <= 1'b1;
                                cnt_q <= per_q;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    default: begin
                        cnt_q <= '0;
                    end
                endcase
            end
        end
    end

    assign expired = exp_q;

    p_expire_after_tick_r10: assert property (@(posedge clk) disable iff (rst)
        expired |-> ($past(tick) && !$past(kick) && $past(state_q) == WD_WATCH));

    p_off_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_OFF) |-> !expired);

    p_grace_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_GRACE) |-> !expired);

    p_armed_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_ARMED) |-> !expired);

    p_count_live_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_WATCH || state_q == WD_GRACE) |-> (cnt_q != '0));

    p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(!tick) && $past(!cfg_change) && $past(!kick) && !$past(rst)) |-> $stable(cnt_q));

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       expired
);
    logic       cfg_change;
    logic       kick;
    wd_timing_t new_timing;

    wdg_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .cfg_change (cfg_change),
        .kick       (kick)
    );

    wdg_code_map #(.EXTENDED(EXTENDED)) u_map (
        .code   (wr_data[CODE_W-1:0]),
        .timing (new_timing)
    );

    wdg_timer_core u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (sec_tick),
        .cfg_change (cfg_change),
        .kick       (kick),
        .new_timing (new_timing),
        .expired    (expired)
    );

endmodule

// File: tb/wdg_supervisor_test.sv
module wdg_supervisor_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // vector: {wr_en, wr_data[7:0], sec_tick, expected expired after the edge}
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b1, 8'h05, 1'b0, 1'b0},  // R6 arm no-grace code 5
        {1'b0, 8'h00, 1'b1, 1'b0},  // R6 armed: ticks ignored
        {1'b0, 8'h00, 1'b1, 1'b0},  // R6
        {1'b1, 8'h0D, 1'b0, 1'b0},  // R3 kick rise starts watch
        {1'b1, 8'h05, 1'b0, 1'b0},  // R3 kick fall, same code
        {1'b0, 8'h00, 1'b1, 1'b1},  // R10 1-tick period expires
        {1'b0, 8'h00, 1'b0, 1'b0},  // R10 single pulse, R11 idle
        {1'b0, 8'h00, 1'b1, 1'b1},  // R10 keeps supervising
        {1'b1, 8'h0D, 1'b1, 1'b0},  // R9 kick beats tick
        {1'b1, 8'h05, 1'b0, 1'b0},  // R9
        {1'b1, 8'h03, 1'b0, 1'b0},  // R7 off
        {1'b0, 8'h00, 1'b1, 1'b0},  // R7
        {1'b0, 8'h00, 1'b1, 1'b0},  // R7
        {1'b1, 8'h0B, 1'b0, 1'b0},  // R7 kick while off
        {1'b0, 8'h00, 1'b1, 1'b0},  // R7
        {1'b1, 8'h04, 1'b1, 1'b0},  // R7 code 4 unlisted
        {1'b0, 8'h00, 1'b1, 1'b0}   // R7
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_ext, rd_bas;
    logic       exp_ext, exp_bas;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_supervisor #(.EXTENDED(1'b1)) uut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_ext), .expired(exp_ext)
    );

    wdg_supervisor #(.EXTENDED(1'b0)) uut_basic (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_bas), .expired(exp_bas)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: drive, pass the edge, sample 1 time unit later
    task automatic cycle(input logic w, input logic [7:0] d, input logic t);
        wr_en = w;
        wr_data = d;
        sec_tick = t;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        sec_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycle(1'b0, 8'h00, 1'b0);
        cycle(1'b0, 8'h00, 1'b0);
        rst = 1'b0;
    endtask

    // n back-to-back ticks; first tick index with a pulse and pulse count
    task automatic run_ticks(input int n, input bit use_basic,
                             output int first, output int pulses);
        first = 0;
        pulses = 0;
        for (int i = 1; i <= n; i++) begin
            cycle(1'b0, 8'h00, 1'b1);
            if ((use_basic ? exp_bas : exp_ext) == 1'b1) begin
                pulses++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int first, pulses;
        #1;
        do_reset();

        // R1 reset state
        check("R1 rd_data", int'(rd_ext), 8'h03);
        check("R1 expired", int'(exp_ext), 0);

        // vector walk on the extended instance
        for (int v = 0; v < NVEC; v++) begin
            cycle(VEC[v][10], VEC[v][9:2], VEC[v][1]);
            check($sformatf("vector %0d R3/R6/R7/R9/R10", v), int'(exp_ext), int'(VEC[v][0]));
        end

        // R2 readback of all bits (code 6 extended, upper bits arbitrary)
        cycle(1'b1, 8'hA6, 1'b0);
        check("R2 readback", int'(rd_ext), 8'hA6);
        cycle(1'b1, 8'h5B, 1'b0);
        check("R2 readback 2", int'(rd_ext), 8'h5B);

        // R5 code 1: grace 3, period 3 -> pulses at 6, 9, 12
        do_reset();
        cycle(1'b1, 8'h01, 1'b0);
        run_ticks(12, 1'b0, first, pulses);
        check("R5 code1 first", first, 6);
        check("R10 code1 pulse count", pulses, 3);

        // R8 kick in grace ignored
        do_reset();
        cycle(1'b1, 8'h01, 1'b0);
        run_ticks(2, 1'b0, first, pulses);
        cycle(1'b1, 8'h09, 1'b0);
        cycle(1'b1, 8'h01, 1'b0);
        run_ticks(4, 1'b0, first, pulses);
        check("R8 kick in grace", first, 4);

        // R9 kick while watching reloads period
        do_reset();
        cycle(1'b1, 8'h01, 1'b0);
        run_ticks(5, 1'b0, first, pulses);
        check("R9 no pulse before kick", pulses, 0);
        cycle(1'b1, 8'h09, 1'b0);
        cycle(1'b1, 8'h01, 1'b0);
        run_ticks(3, 1'b0, first, pulses);
        check("R9 reload full period", first, 3);

        // R11 idle clocks do not advance
        do_reset();
        cycle(1'b1, 8'h01, 1'b0);
        for (int k = 0; k < 20; k++) cycle(1'b0, 8'h00, 1'b0);
        check("R11 idle no pulse", int'(exp_ext), 0);
        run_ticks(6, 1'b0, first, pulses);
        check("R11 ticks only", first, 6);

        // R3 same-code rewrite does not restart grace
        do_reset();
        cycle(1'b1, 8'h01, 1'b0);
        run_ticks(2, 1'b0, first, pulses);
        cycle(1'b1, 8'h11, 1'b0);
        run_ticks(4, 1'b0, first, pulses);
        check("R3 same code no restart", first, 4);

        // R5 code 2: grace 60, period 1
        do_reset();
        cycle(1'b1, 8'h02, 1'b0);
        run_ticks(62, 1'b0, first, pulses);
        check("R5 code2 first", first, 61);

        // R5 code 7: grace 60, period 10
        do_reset();
        cycle(1'b1, 8'h07, 1'b0);
        run_ticks(70, 1'b0, first, pulses);
        check("R5 code7 first", first, 70);

        // R6 code 6: needs kick, then 10
        do_reset();
        cycle(1'b1, 8'h06, 1'b0);
        run_ticks(15, 1'b0, first, pulses);
        check("R6 code6 armed silent", pulses, 0);
        cycle(1'b1, 8'h0E, 1'b0);
        run_ticks(10, 1'b0, first, pulses);
        check("R6 code6 after kick", first, 10);

        // R4 basic table
        do_reset();
        cycle(1'b1, 8'h05, 1'b0);
        run_ticks(4, 1'b1, first, pulses);
        check("R4 basic code5 first", first, 2);
        check("R4 basic code5 pulses", pulses, 3);
        do_reset();
        cycle(1'b1, 8'h06, 1'b0);
        run_ticks(20, 1'b1, first, pulses);
        check("R4 basic code6 first", first, 20);
        do_reset();
        cycle(1'b1, 8'h07, 1'b0);
        run_ticks(120, 1'b1, first, pulses);
        check("R4 basic code7 first", first, 120);

        // R7 codes without basic entries stay silent
        do_reset();
        cycle(1'b1, 8'h01, 1'b0);
        run_ticks(100, 1'b1, first, pulses);
        check("R7 basic code1 silent", pulses, 0);
        cycle(1'b1, 8'h02, 1'b0);
        run_ticks(100, 1'b1, first, pulses);
        check("R7 basic code2 silent", pulses, 0);

        // R1 reset mid-supervision
        do_reset();
        cycle(1'b1, 8'h05, 1'b0);
        cycle(1'b1, 8'h0D, 1'b0);
        rst = 1'b1;
        cycle(1'b0, 8'h00, 1'b1);
        rst = 1'b0;
        check("R1 reset reg", int'(rd_ext), 8'h03);
        run_ticks(10, 1'b0, first, pulses);
        check("R1 reset clears timing", pulses, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule